// File: doc/BRIEF.md
# Code/Data Memory Select Controller

This block drives the chip selects of a small microcontroller-facing memory subsystem. The subsystem has three priority levels. The top level holds the SRAM, a register window and a peripheral-I/O window. The middle level is EEPROM and the bottom level is Flash. The controller has two read strobes: a code-fetch strobe and a data-read strobe. It also has a data-write strobe. An external address decoder supplies one hit line per region. The controller combines these hit lines with an 8-bit mapping register. That register states, for each region, whether instruction fetches, data accesses or both may reach it. The result is at most one chip select.

The mapping register loads a build-time value at reset. Software can then rewrite it through a simple write port. This lets the code/data placement change while running, for example moving Flash out of data space and EEPROM into code space. Bit 7 of the register enables the peripheral-I/O window, and the same bit is shown on a mode output.

Top module: `memsel_ctrl`

## Requirements
- R1: At reset the mapping register (`map_q`) holds parameter `MAP_INIT`, with bits 6 and 5 forced to zero.
- R2: When `map_we` is high at a rising edge, `map_q` becomes `map_wdata` with bits 6 and 5 cleared. Without `map_we`, `map_q` keeps its value. Bits 6 and 5 always read zero.
- R3: A code fetch (`fetch_en`) can select the top level (SRAM, register window, peripheral-I/O window) only when `map_q[0]` is 1. It can select EEPROM only when `map_q[1]` is 1, and Flash only when `map_q[2]` is 1.
- R4: A data read (`dread_en`) always reaches the top level. It reaches EEPROM only when `map_q[3]` is 1, and Flash only when `map_q[4]` is 1.
- R5: A data write (`dwrite_en`) follows the same rules as a data read. It always reaches the top level, and it uses only `map_q[3]` and `map_q[4]` for EEPROM and Flash. It never uses bits 0 to 2.
- R6: The peripheral-I/O window can be selected only while `map_q[7]` is 1. `pio_mode` equals `map_q[7]`.
- R7: A region is eligible when its hit line is high and at least one active strobe permits it. Among eligible regions the fixed order is: peripheral-I/O window, register window, SRAM, EEPROM, Flash. Only the first eligible region in that order is selected.
- R8: A region that hits but is blocked for every active strobe does not take priority. Selection passes down to the next eligible region.
- R9: At most one chip select is high at any time. No chip select is high when all three strobes are low or when no region is eligible.
- R10: Chip selects are combinational from the registered map. A register write changes them only from the cycle after the write edge, never within the cycle in which the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_en | input | 1 | Code-fetch strobe, active high |
| dread_en | input | 1 | Data-read strobe, active high |
| dwrite_en | input | 1 | Data-write strobe, active high |
| hit_sram | input | 1 | Decoder hit, SRAM |
| hit_regwin | input | 1 | Decoder hit, register window |
| hit_pio | input | 1 | Decoder hit, peripheral-I/O window |
| hit_eeprom | input | 1 | Decoder hit, EEPROM |
| hit_flash | input | 1 | Decoder hit, Flash |
| map_we | input | 1 | Mapping register write enable |
| map_wdata | input | 8 | Mapping register write data |
| map_q | output | 8 | Mapping register contents |
| cs_sram | output | 1 | SRAM chip select |
| cs_regwin | output | 1 | Register window select |
| cs_pio | output | 1 | Peripheral-I/O window select |
| cs_eeprom | output | 1 | EEPROM chip select |
| cs_flash | output | 1 | Flash chip select |
| pio_mode | output | 1 | Peripheral-I/O mode flag |

## Verification
Directed sequences drive each strobe alone with all five hit lines high. They remove the hit lines one at a time from the top, so that the priority order is separated from the mapping gating. Further directed sequences block a hit region and leave a lower one open, to show that selection passes down instead of going dead. They also drive writes with the map bits for reads cleared but the fetch bits set, which tells write gating apart from fetch gating. Random sequences mix several strobes at once, random hit patterns and register writes in the middle of a run. These exercise the "any active strobe permits" rule and the rule that a write takes effect only on the following cycle.

// File: rtl/memsel_ctrl.sv
module memsel_ctrl #(
  parameter logic [7:0] MAP_INIT = 8'h17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_en,
  input  logic       dread_en,
  input  logic       dwrite_en,
  input  logic       hit_sram,
  input  logic       hit_regwin,
  input  logic       hit_pio,
  input  logic       hit_eeprom,
  input  logic       hit_flash,
  input  logic       map_we,
  input  logic [7:0] map_wdata,
  output logic [7:0] map_q,
  output logic       cs_sram,
  output logic       cs_regwin,
  output logic       cs_pio,
  output logic       cs_eeprom,
  output logic       cs_flash,
  output logic       pio_mode
);
  localparam logic [7:0] USED_MASK = 8'h9F;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_q <= MAP_INIT & USED_MASK;
    else if (map_we) map_q <= map_wdata & USED_MASK;
  end

  logic data_acc, top_ok, ee_ok, fl_ok;
  logic el_pio, el_reg, el_sram, el_ee, el_fl;

  assign data_acc = dread_en | dwrite_en;
  assign top_ok   = data_acc | (fetch_en & map_q[0]);
  assign ee_ok    = (fetch_en & map_q[1]) | (data_acc & map_q[3]);
  assign fl_ok    = (fetch_en & map_q[2]) | (data_acc & map_q[4]);

  assign el_pio  = hit_pio & map_q[7] & top_ok;
  assign el_reg  = hit_regwin & top_ok;
  assign el_sram = hit_sram & top_ok;
  assign el_ee   = hit_eeprom & ee_ok;
  assign el_fl   = hit_flash & fl_ok;

  assign cs_pio    = el_pio;
  assign cs_regwin = el_reg & ~el_pio;
  assign cs_sram   = el_sram & ~el_reg & ~el_pio;
  assign cs_eeprom = el_ee & ~el_sram & ~el_reg & ~el_pio;
  assign cs_flash  = el_fl & ~el_ee & ~el_sram & ~el_reg & ~el_pio;
  assign pio_mode  = map_q[7];
endmodule

// File: rtl/memsel_ctrl_chk.sv
module memsel_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_en,
  input logic       dread_en,
  input logic       dwrite_en,
  input logic       hit_sram,
  input logic       hit_regwin,
  input logic       hit_pio,
  input logic       hit_eeprom,
  input logic       hit_flash,
  input logic       map_we,
  input logic [7:0] map_wdata,
  input logic [7:0] map_q,
  input logic       cs_sram,
  input logic       cs_regwin,
  input logic       cs_pio,
  input logic       cs_eeprom,
  input logic       cs_flash,
  input logic       pio_mode
);
  logic [4:0] cs_all;
  assign cs_all = {cs_pio, cs_regwin, cs_sram, cs_eeprom, cs_flash};

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_all)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !(fetch_en || dread_en || dwrite_en) |-> cs_all == 5'd0); // R9
  AST_MAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n) map_we |=> map_q == ($past(map_wdata) & 8'h9F)); // R2
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !map_we |=> $stable(map_q)); // R2
  AST_PIO_GATED: assert property (@(posedge clk) disable iff (!rst_n) cs_pio |-> (pio_mode && hit_pio)); // R6
  AST_EE_FETCH: assert property (@(posedge clk) disable iff (!rst_n) (cs_eeprom && fetch_en && !dread_en && !dwrite_en) |-> map_q[1]); // R3
  AST_FL_DATA: assert property (@(posedge clk) disable iff (!rst_n) (cs_flash && !fetch_en) |-> map_q[4]); // R4
  AST_FL_LOWEST: assert property (@(posedge clk) disable iff (!rst_n) (cs_flash && (dread_en || dwrite_en)) |-> (!hit_sram && !hit_regwin)); // R7
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n) (hit_eeprom && hit_flash && fetch_en && !dread_en && !dwrite_en && !map_q[1] && map_q[2] && !hit_sram && !hit_regwin && !hit_pio) |-> cs_flash); // R8
endmodule

bind memsel_ctrl memsel_ctrl_chk u_chk (.*);

// File: tb/tb_memsel_ctrl.sv
module tb_memsel_ctrl;
  localparam logic [7:0] INIT = 8'hFF;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_en = 0, dread_en = 0, dwrite_en = 0;
  logic hit_sram = 0, hit_regwin = 0, hit_pio = 0, hit_eeprom = 0, hit_flash = 0;
  logic map_we = 0;
  logic [7:0] map_wdata = 8'h00;
  logic [7:0] map_q;
  logic cs_sram, cs_regwin, cs_pio, cs_eeprom, cs_flash, pio_mode;
  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl;
  bit done = 0;

  always #10 clk = ~clk;

  memsel_ctrl #(.MAP_INIT(INIT)) dut (.*);

  function automatic logic [5:0] exp_sel(input logic [7:0] m, input logic f, input logic r,
                                         input logic w, input logic [4:0] h);
    logic d, top, ee, fl;
    logic [4:0] el;
    d = r | w;
    top = d | (f & m[0]);
    ee = (f & m[1]) | (d & m[3]);
    fl = (f & m[2]) | (d & m[4]);
    el = {h[4] & m[7] & top, h[3] & top, h[2] & top, h[1] & ee, h[0] & fl};
    if (el[4]) return {m[7], 5'b10000};
    if (el[3]) return {m[7], 5'b01000};
    if (el[2]) return {m[7], 5'b00100};
    if (el[1]) return {m[7], 5'b00010};
    if (el[0]) return {m[7], 5'b00001};
    return {m[7], 5'b00000};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // h = {pio, regwin, sram, eeprom, flash}
  task automatic step(input logic f, input logic r, input logic w, input logic [4:0] h,
                      input logic we, input logic [7:0] wd, input string tag);
    @(negedge clk);
    fetch_en = f; dread_en = r; dwrite_en = w;
    {hit_pio, hit_regwin, hit_sram, hit_eeprom, hit_flash} = h;
    map_we = we; map_wdata = wd;
    #5;
    check(tag, {2'b00, pio_mode, cs_pio, cs_regwin, cs_sram, cs_eeprom, cs_flash},
          {2'b00, exp_sel(mdl, f, r, w, h)});
    check("R2 map readback", map_q, mdl);
    @(posedge clk); #1;
    if (we) mdl = wd & 8'h9F;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    mdl = INIT & 8'h9F;
    #35;
    check("R1 reset map", map_q, 8'h9F);
    rst_n = 1'b1;
    // R2 write with unused bits set
    step(0, 0, 0, 5'b00000, 1, 8'h67, "R9 idle");
    check("R2 unused bits zero", map_q, 8'h07);
    // map 07: fetch to all, no data to EE/Flash, pio off
    step(1, 0, 0, 5'b11111, 0, 0, "R6 R7 fetch all hits, pio off");
    step(0, 1, 0, 5'b00011, 0, 0, "R4 read blocked ee/flash");
    step(0, 0, 1, 5'b00011, 0, 0, "R5 write ignores code bits");
    step(0, 1, 0, 5'b00100, 0, 0, "R4 read sram always");
    // R10: write presented now, selects use old map
    step(0, 1, 0, 5'b00010, 1, 8'h98, "R10 write same cycle");
    step(0, 1, 0, 5'b00010, 0, 0, "R4 read ee after map");
    step(1, 0, 0, 5'b00111, 0, 0, "R3 fetch blocked all");
    step(1, 0, 0, 5'b11111, 0, 0, "R3 R9 fetch nothing");
    step(0, 0, 1, 5'b11111, 0, 0, "R6 R7 write pio top");
    step(0, 0, 1, 5'b01111, 0, 0, "R7 regwin");
    step(0, 0, 1, 5'b00011, 0, 0, "R7 ee over flash");
    step(0, 0, 0, 5'b11111, 1, 8'h94, "R9 no strobe");
    step(1, 0, 0, 5'b00011, 0, 0, "R8 ee blocked falls to flash");
    step(0, 1, 0, 5'b00011, 0, 0, "R8 ee blocked for read, flash ok");
    step(1, 1, 0, 5'b00110, 1, 8'h01, "R7 mixed strobes");
    step(1, 0, 0, 5'b00110, 0, 0, "R3 fetch sram via bit0");
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] s;
      logic [4:0] h;
      logic we;
      s = 3'($urandom);
      h = 5'($urandom);
      we = ($urandom % 8) == 0;
      step(s[0], s[1], s[2], h, we, 8'($urandom), "R3 R4 R5 R6 R7 R8 R9 R10 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule